// File: doc/BRIEF.md
# Shortened Hamming Single-Error Corrector

This block protects a 3-bit data word with three even-parity check bits. The result is a 6-bit codeword that survives any single flipped bit. The encoder and the decoder are independent paths. Each path has its own valid-qualified input and a registered output that appears one clock later, so a link can encode on one side and decode on the other in the same cycle.

The decoder recomputes the three checks over the received word. The failing checks form a syndrome, and the syndrome is the number of the faulty bit position. The decoder flips that bit and returns the repaired data together with the syndrome and two status flags. A syndrome of 7 names no position in a 6-bit word, so the decoder reports it as uncorrectable.

Positions are numbered 1 to 6 starting from the most significant bit of the code bus. Position 1 is bus bit 5 and position 6 is bus bit 0.

Top module: `sec_codec`

## Requirements
- R1: Encoded data placement: data bit 2 goes to position 3 (bus bit 3), data bit 1 to position 5 (bus bit 1), and data bit 0 to position 6 (bus bit 0).
- R2: Check bits: position 1 = pos3 XOR pos5, position 2 = pos3 XOR pos6, and position 4 = pos5 XOR pos6. This gives data 0..7 the codewords 000000, 010101, 100110, 110011, 111000, 101101, 011110 and 001011.
- R3: `enc_valid_o` is high exactly one clock after a clock on which `enc_valid_i` was high. `enc_code_o` updates only on such clocks and otherwise holds its value.
- R4: `dec_syndrome_o` is built from three parities: bit 0 over positions {1,3,5}, bit 1 over {2,3,6} and bit 2 over {4,5,6}. For a single flipped bit, it equals that bit's position.
- R5: When a valid codeword arrives with one bit flipped in any of positions 1..6, `dec_data_o` returns the original data, `dec_corrected_o` is 1 and `dec_uncorr_o` is 0.
- R6: A syndrome of 0 passes the data through unchanged, with both flags low.
- R7: A syndrome of 7 sets `dec_uncorr_o`, clears `dec_corrected_o`, and returns the data bits of the received word without repair.
- R8: `dec_valid_o` is high exactly one clock after a clock on which `dec_valid_i` was high. The decode outputs update only on such clocks.
- R9: An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | 3 | Data to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 6 | Encoded word, position 1 at bit 5 |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 6 | Received word, position 1 at bit 5 |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 3 | Corrected data |
| dec_syndrome_o | output | 3 | Faulty position, 0 if none |
| dec_corrected_o | output | 1 | A single bit was repaired |
| dec_uncorr_o | output | 1 | Syndrome names no position |

## Verification
The assertions assume that both valid inputs are known after reset, and that the data and code inputs are known on any clock where their valid is high. They make no assumption about how many bits of a received word are wrong. This holds because they only link the flags and the syndrome to each other and to the encoder's own output. The stimulus drives known values at all times. It holds each valid low except on the cycles that carry a word. It sends only clean codewords, words with a single flipped bit, and one deliberate double flip whose syndrome is 7.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int DATA_W = 3;
  localparam int CHK_W  = 3;              // needs 2**CHK_W - 1 >= CW_W
  localparam int CW_W   = DATA_W + CHK_W;

  function automatic bit is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // positions covered by check 2**k, as a bus mask (position 1 = MSB)
  function automatic logic [CW_W-1:0] cover_mask(int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CW_W; p++)
      if (((p >> k) & 1) == 1) m[CW_W-p] = 1'b1;
    return m;
  endfunction

  function automatic logic [CW_W-1:0] place_data(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    int j;
    c = '0;
    j = DATA_W - 1;
    for (int p = 1; p <= CW_W; p++)
      if (!is_chk_pos(p) && j >= 0) begin
        c[CW_W-p] = d[j];
        j--;
      end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pull_data(logic [CW_W-1:0] c);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = DATA_W - 1;
    for (int p = 1; p <= CW_W; p++)
      if (!is_chk_pos(p) && j >= 0) begin
        d[j] = c[CW_W-p];
        j--;
      end
    return d;
  endfunction
endpackage

// File: rtl/sec_enc.sv
module sec_enc
  import sec_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o
);
  logic [CW_W-1:0]  placed;
  logic [CHK_W-1:0] chk_bit;
  logic [CW_W-1:0]  chk_vec;

  assign placed = place_data(data_i);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [CW_W-1:0] COV = cover_mask(k);
    assign chk_bit[k] = ^(placed & COV);
  end

  always_comb begin
    chk_vec = '0;
    for (int k = 0; k < CHK_W; k++) chk_vec[CW_W-(1<<k)] = chk_bit[k];
  end

  assign code_o = placed | chk_vec;
endmodule

// File: rtl/sec_dec.sv
module sec_dec
  import sec_pkg::*;
(
  input  logic [CW_W-1:0]   code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o,
  output logic              corr_o,
  output logic              unc_o
);
  logic [CW_W-1:0] fixed;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [CW_W-1:0] COV = cover_mask(k);
    assign syn_o[k] = ^(code_i & COV);
  end

  always_comb begin
    fixed  = code_i;
    corr_o = 1'b0;
    unc_o  = 1'b0;
    if (syn_o != '0) begin
      if (int'(syn_o) <= CW_W) begin
        fixed[CW_W-int'(syn_o)] = ~code_i[CW_W-int'(syn_o)];
        corr_o = 1'b1;
      end else begin
        unc_o = 1'b1;  // points past the shortened word
      end
    end
  end

  assign data_o = pull_data(fixed);
endmodule

// File: rtl/sec_codec.sv
module sec_codec
  import sec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CW_W-1:0]   enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CHK_W-1:0]  dec_syndrome_o,
  output logic              dec_corrected_o,
  output logic              dec_uncorr_o
);
  logic [CW_W-1:0]   enc_code_d;
  logic [DATA_W-1:0] dec_data_d;
  logic [CHK_W-1:0]  dec_syn_d;
  logic              dec_corr_d, dec_unc_d;

  sec_enc u_enc (.data_i(enc_data_i), .code_o(enc_code_d));

  sec_dec u_dec (
    .code_i(dec_code_i), .data_o(dec_data_d), .syn_o(dec_syn_d),
    .corr_o(dec_corr_d), .unc_o(dec_unc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o     <= 1'b0;
      dec_data_o      <= '0;
      dec_syndrome_o  <= '0;
      dec_corrected_o <= 1'b0;
      dec_uncorr_o    <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o      <= dec_data_d;
        dec_syndrome_o  <= dec_syn_d;
        dec_corrected_o <= dec_corr_d;
        dec_uncorr_o    <= dec_unc_d;
      end
    end
  end
endmodule

// File: rtl/sec_codec_chk.sv
module sec_codec_chk
  import sec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enc_valid_i,
  input logic [DATA_W-1:0] enc_data_i,
  input logic              enc_valid_o,
  input logic [CW_W-1:0]   enc_code_o,
  input logic              dec_valid_i,
  input logic [CW_W-1:0]   dec_code_i,
  input logic              dec_valid_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic [CHK_W-1:0]  dec_syndrome_o,
  input logic              dec_corrected_o,
  input logic              dec_uncorr_o
);
  a_r1_data_placed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> {enc_code_o[3], enc_code_o[1], enc_code_o[0]} == $past(enc_data_i));

  a_r2_checks_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> (enc_code_o[5] == (enc_code_o[3] ^ enc_code_o[1]))
                 && (enc_code_o[4] == (enc_code_o[3] ^ enc_code_o[0]))
                 && (enc_code_o[2] == (enc_code_o[1] ^ enc_code_o[0])));

  a_r3_enc_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);

  a_r3_enc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> !enc_valid_o && $stable(enc_code_o));

  a_r5_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_corrected_o && dec_uncorr_o));

  a_r6_clean_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_syndrome_o == '0 |-> !dec_corrected_o && !dec_uncorr_o);

  a_r7_unc_syn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_uncorr_o |-> dec_syndrome_o == 3'd7);

  a_r8_dec_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);

  a_r8_dec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !dec_valid_o && $stable(dec_data_o) && $stable(dec_syndrome_o));
endmodule

bind sec_codec sec_codec_chk u_chk (.*);

// File: tb/sec_codec_test.sv
module sec_codec_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enc_valid_i = 1'b0;
  logic [2:0] enc_data_i = '0;
  logic       enc_valid_o;
  logic [5:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [5:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [2:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_corrected_o, dec_uncorr_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [2:0] data;
    logic [2:0] syn;
    logic       corr;
    logic       unc;
  } dec_exp_t;

  logic [5:0] enc_q[$];
  dec_exp_t   dec_q[$];

  // R2 codeword table, data 0..7
  logic [5:0] cw_tab [8] = '{6'b000000, 6'b010101, 6'b100110, 6'b110011,
                             6'b111000, 6'b101101, 6'b011110, 6'b001011};

  always #4 clk_i = ~clk_i;

  sec_codec uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(bit ev, logic [2:0] ed, bit dv, logic [5:0] dc, dec_exp_t de);
    @(negedge clk_i);
    enc_valid_i = ev; enc_data_i = ed;
    dec_valid_i = dv; dec_code_i = dc;
    if (ev) enc_q.push_back(cw_tab[ed]);
    if (dv) dec_q.push_back(de);
  endtask

  // monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (enc_valid_o) begin
      if (enc_q.size() == 0) check("R3 unexpected enc_valid_o", 1, 0);
      else begin
        logic [5:0] e;
        e = enc_q.pop_front();
        check("R1/R2 enc_code_o", 32'(enc_code_o), 32'(e));
      end
    end
    if (dec_valid_o) begin
      if (dec_q.size() == 0) check("R8 unexpected dec_valid_o", 1, 0);
      else begin
        dec_exp_t d;
        d = dec_q.pop_front();
        check("R5 dec_data_o", 32'(dec_data_o), 32'(d.data));
        check("R4 dec_syndrome_o", 32'(dec_syndrome_o), 32'(d.syn));
        check("R5/R6 dec_corrected_o", 32'(dec_corrected_o), 32'(d.corr));
        check("R7 dec_uncorr_o", 32'(dec_uncorr_o), 32'(d.unc));
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    dec_exp_t de, none;
    none = '{3'd0, 3'd0, 1'b0, 1'b0};
    repeat (2) @(negedge clk_i);
    // R9 reset state
    check("R9 enc_valid_o", 32'(enc_valid_o), 0);
    check("R9 enc_code_o", 32'(enc_code_o), 0);
    check("R9 dec_valid_o", 32'(dec_valid_o), 0);
    check("R9 dec_flags", 32'({dec_data_o, dec_syndrome_o, dec_corrected_o, dec_uncorr_o}), 0);
    rst_ni = 1'b1;

    // R1 R2 R6: encode every value, decode the clean codeword alongside
    for (int d = 0; d < 8; d++) begin
      de = '{3'(d), 3'd0, 1'b0, 1'b0};
      drive(1'b1, 3'(d), 1'b1, cw_tab[d], de);
    end
    // R4 R5: every single-bit error in every codeword
    for (int d = 0; d < 8; d++)
      for (int p = 1; p <= 6; p++) begin
        de = '{3'(d), 3'(p), 1'b1, 1'b0};
        drive(1'b0, 3'd0, 1'b1, cw_tab[d] ^ (6'b100000 >> (p - 1)), de);
      end
    // R7: positions 3 and 4 flipped on 000000 -> syndrome 7, raw data 100
    de = '{3'b100, 3'd7, 1'b0, 1'b1};
    drive(1'b1, 3'd5, 1'b1, 6'b001100, de);
    drive(1'b0, 3'd2, 1'b0, 6'b111111, none);
    repeat (3) @(negedge clk_i);
    // R3 R8: idle cycles leave outputs held and valids low
    check("R3 enc_valid_o idle", 32'(enc_valid_o), 0);
    check("R3 enc_code_o held", 32'(enc_code_o), 32'(cw_tab[5]));
    check("R8 dec_valid_o idle", 32'(dec_valid_o), 0);
    check("R8 dec_syndrome_o held", 32'(dec_syndrome_o), 7);
    check("R7 dec_data_o held", 32'(dec_data_o), 32'(3'b100));
    check("R3 enc queue drained", 32'(enc_q.size()), 0);
    check("R8 dec queue drained", 32'(dec_q.size()), 0);
    // R9 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R9 async enc_code_o", 32'(enc_code_o), 0);
    check("R9 async dec outputs", 32'({dec_data_o, dec_syndrome_o, dec_uncorr_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    summary();
    $finish;
  end
endmodule